// File: doc/BRIEF.md
# Digital PID Duty-Cycle Compensator

This block is the control-law stage of a digitally regulated switching power supply. It replaces the analog error amplifier and its compensation network. Once per switching period a digitized output-voltage code arrives with a strobe. The block subtracts that code from a reference code and runs a fixed-point proportional-integral or proportional-integral-derivative update. The result is a duty-cycle command for a digital PWM stage. The duty command is wider than the voltage code, so every settled error has a distinct duty value and the loop does not limit-cycle.

Gain coefficients sit in several banks, one for each operating mode: normal regulation, transient recovery and fault handling. The mode presented with each sample picks the bank for that update. Switching banks never disturbs the integrator. The integrator saturates at its own signed limits and stops integrating while the output is pinned at a programmable duty floor or ceiling. Each update takes a fixed three-cycle latency, which stands in for the computational delay of the loop.

Top module: `pid_duty_ctrl`

## Requirements
- R1: The error of an update is ref_code minus sample_code, both read as unsigned, and is formed as a signed value one bit wider than the codes.
- R2: When sample_valid is high in cycle n, duty_valid is high in cycle n+3 for exactly one cycle and low in cycles n+1 and n+2.
- R3: Each coefficient is a signed Q4.12 value (4096 means 1.0). Each product of a coefficient and its operand is rounded to an integer as floor((coef*x + 2048) / 4096) before the terms are summed. The unclamped command is u = P + I + D.
- R4: The integrator adds the rounded ki*error term at each update, saturates at +(2^(ACC_W-1)-1) and -2^(ACC_W-1), and changes at no other time.
- R5: When u falls outside [duty_min, duty_max], the integrator keeps its previous value for that update and I is taken as that value.
- R6: duty_cmd equals duty_min when u < duty_min, duty_max when u > duty_max, and u otherwise.
- R7: With use_deriv = 1 the derivative operand is the present error minus the error of the previous update. With use_deriv = 0 the D term is zero. The stored previous error is refreshed in both modes.
- R8: op_mode 0 (normal) selects bank 0, 1 (transient) selects bank 1, 2 (fault) selects bank 2, and any value at or above NBANK selects the highest bank. Bank k of each coefficient bus occupies bits [k*COEF_W +: COEF_W].
- R9: sample_code, ref_code, op_mode, use_deriv and the coefficient buses are taken only in the cycle where sample_valid is high, so later changes do not affect that update. Changing banks does not clear the integrator.
- R10: Reset drives duty_cmd to 0 and duty_valid low, and clears both the integrator and the stored previous error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Strobe starting one update |
| sample_code | input | ERR_W | Digitized output-voltage code |
| ref_code | input | ERR_W | Target voltage code |
| op_mode | input | 2 | Operating mode: 0 normal, 1 transient, 2 fault |
| use_deriv | input | 1 | 1 selects PID, 0 selects PI |
| kp_banks | input | NBANK*COEF_W | Proportional gains, one per bank |
| ki_banks | input | NBANK*COEF_W | Integral gains, one per bank |
| kd_banks | input | NBANK*COEF_W | Derivative gains, one per bank |
| duty_min | input | DUTY_W | Lowest allowed duty command |
| duty_max | input | DUTY_W | Highest allowed duty command |
| duty_cmd | output | DUTY_W | Duty-cycle command to the PWM |
| duty_valid | output | 1 | One-cycle strobe marking a new duty_cmd |

## Verification
The assertions check on every cycle that the strobe latency is fixed and that each command lies within the duty window. They also check that the integrator holds between updates and during clamped updates, that the captured operands and coefficients stay put between strobes, and that the D term stays zero in PI mode. Only the bench scenarios can show the arithmetic itself. That covers the error sign, rounding of ties, a chain of updates that carries integrator state across bank changes, the fallback bank for the unused mode code, integrator saturation seen through the duty value, and clearing of the stored state by reset.

// File: rtl/pid_pkg.sv
`timescale 1ns/1ps
package pid_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_NORMAL    = 2'd0,
      MODE_TRANSIENT = 2'd1,
      MODE_FAULT     = 2'd2,
      MODE_SPARE     = 2'd3
   } op_mode_e;

   // operand slots of the three multipliers
   localparam int SLOT_P = 0;
   localparam int SLOT_I = 1;
   localparam int SLOT_D = 2;
   localparam int NSLOT  = 3;
endpackage

// File: rtl/pid_bank_sel.sv
`timescale 1ns/1ps
module pid_bank_sel
   import pid_pkg::*;
#(
   parameter int NBANK  = 3,
   parameter int COEF_W = 16
) (
   input  op_mode_e                  mode_i,
   input  logic [NBANK*COEF_W-1:0]   kp_bus_i,
   input  logic [NBANK*COEF_W-1:0]   ki_bus_i,
   input  logic [NBANK*COEF_W-1:0]   kd_bus_i,
   output logic signed [COEF_W-1:0]  kp_o,
   output logic signed [COEF_W-1:0]  ki_o,
   output logic signed [COEF_W-1:0]  kd_o
);
   if (NBANK < 1 || NBANK > (1 << MODE_W)) begin : g_bad_nbank
      $error("pid_bank_sel: NBANK must lie between 1 and 4");
   end

   logic [NBANK-1:0][COEF_W-1:0] kp_arr, ki_arr, kd_arr;

   for (genvar b = 0; b < NBANK; b++) begin : g_unpack
      assign kp_arr[b] = kp_bus_i[b*COEF_W +: COEF_W];
      assign ki_arr[b] = ki_bus_i[b*COEF_W +: COEF_W];
      assign kd_arr[b] = kd_bus_i[b*COEF_W +: COEF_W];
   end

   if (NBANK == 1) begin : g_single
      logic unused_mode;
      assign unused_mode = ^mode_i;
      assign kp_o = $signed(kp_arr[0]);
      assign ki_o = $signed(ki_arr[0]);
      assign kd_o = $signed(kd_arr[0]);
   end else begin : g_multi
      localparam int IDX_W = $clog2(NBANK);
      logic [IDX_W-1:0] idx;

      // unused mode codes fall back to the highest bank (R8)
      always_comb begin
         if (32'(mode_i) >= NBANK) idx = IDX_W'(NBANK - 1);
         else                      idx = IDX_W'(mode_i);
      end

      assign kp_o = $signed(kp_arr[idx]);
      assign ki_o = $signed(ki_arr[idx]);
      assign kd_o = $signed(kd_arr[idx]);
   end
endmodule

// File: rtl/pid_term_mul.sv
`timescale 1ns/1ps
module pid_term_mul #(
   parameter int IN_W   = 10,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 12,
   localparam int PROD_W = IN_W + COEF_W,
   localparam int OUT_W  = PROD_W - FRAC_W
) (
   input  logic signed [IN_W-1:0]   x_i,
   input  logic signed [COEF_W-1:0] coef_i,
   output logic signed [OUT_W-1:0]  term_o
);
   if (FRAC_W < 1 || FRAC_W >= COEF_W) begin : g_bad_frac
      $error("pid_term_mul: FRAC_W must be at least 1 and below COEF_W");
   end

   localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC_W - 1);

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] biased;

   // round to nearest, ties toward plus infinity (R3)
   assign prod   = PROD_W'(x_i) * PROD_W'(coef_i);
   assign biased = prod + HALF;
   assign term_o = OUT_W'(biased >>> FRAC_W);
endmodule

// File: rtl/pid_integ_clamp.sv
`timescale 1ns/1ps
module pid_integ_clamp #(
   parameter int ACC_W  = 18,
   parameter int TERM_W = 14,
   parameter int DUTY_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [TERM_W-1:0] p_i,
   input  logic signed [TERM_W-1:0] i_i,
   input  logic signed [TERM_W-1:0] d_i,
   input  logic [DUTY_W-1:0]        dmin_i,
   input  logic [DUTY_W-1:0]        dmax_i,
   output logic [DUTY_W-1:0]        duty_o,
   output logic                     valid_o
);
   if (ACC_W < DUTY_W + 1) begin : g_bad_acc
      $error("pid_integ_clamp: ACC_W must cover the duty range plus sign");
   end

   localparam int WIDE_W = ((ACC_W > TERM_W) ? ACC_W : TERM_W) + 2;
   localparam logic signed [WIDE_W-1:0] ACC_HI =
      WIDE_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
   localparam logic signed [WIDE_W-1:0] ACC_LO =
      WIDE_W'(-(64'sd1 <<< (ACC_W - 1)));

   logic signed [ACC_W-1:0]  integ_q;
   logic signed [ACC_W-1:0]  integ_next;
   logic signed [WIDE_W-1:0] acc_sum;
   logic signed [WIDE_W-1:0] u_sum;
   logic signed [WIDE_W-1:0] lo_lim, hi_lim;
   logic                     below, above;

   // saturating accumulate (R4)
   always_comb begin
      acc_sum = WIDE_W'(integ_q) + WIDE_W'(i_i);
      if (acc_sum > ACC_HI)      integ_next = ACC_W'(ACC_HI);
      else if (acc_sum < ACC_LO) integ_next = ACC_W'(ACC_LO);
      else                       integ_next = ACC_W'(acc_sum);
   end

   assign u_sum  = WIDE_W'(p_i) + WIDE_W'(integ_next) + WIDE_W'(d_i);
   assign lo_lim = $signed(WIDE_W'(dmin_i));
   assign hi_lim = $signed(WIDE_W'(dmax_i));
   assign below  = (u_sum < lo_lim);
   assign above  = (u_sum > hi_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         integ_q <= '0;
         duty_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= in_valid;
         if (in_valid) begin
            if (below) begin
               duty_o <= dmin_i;
            end else if (above) begin
               duty_o <= dmax_i;
            end else begin
               duty_o  <= DUTY_W'(u_sum);
               integ_q <= integ_next;
            end
         end
      end
   end

   assert_integ_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(integ_q));

   assert_integ_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (u_sum < $signed(WIDE_W'(dmin_i)) || u_sum > $signed(WIDE_W'(dmax_i))))
      |=> $stable(integ_q));

   assert_duty_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (duty_o >= $past(dmin_i) && duty_o <= $past(dmax_i)));
endmodule

// File: rtl/pid_duty_ctrl.sv
`timescale 1ns/1ps
module pid_duty_ctrl
   import pid_pkg::*;
#(
   parameter int ERR_W  = 8,
   parameter int DUTY_W = 9,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 12,
   parameter int ACC_W  = 18,
   parameter int NBANK  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_valid,
   input  logic [ERR_W-1:0]        sample_code,
   input  logic [ERR_W-1:0]        ref_code,
   input  logic [1:0]              op_mode,
   input  logic                    use_deriv,
   input  logic [NBANK*COEF_W-1:0] kp_banks,
   input  logic [NBANK*COEF_W-1:0] ki_banks,
   input  logic [NBANK*COEF_W-1:0] kd_banks,
   input  logic [DUTY_W-1:0]       duty_min,
   input  logic [DUTY_W-1:0]       duty_max,
   output logic [DUTY_W-1:0]       duty_cmd,
   output logic                    duty_valid
);
   localparam int E_W    = ERR_W + 1;
   localparam int X_W    = ERR_W + 2;
   localparam int TERM_W = X_W + COEF_W - FRAC_W;

   if (DUTY_W <= ERR_W) begin : g_bad_duty
      $error("pid_duty_ctrl: duty command must be wider than the sample code");
   end

   // bank selection from the live mode; captured with the sample (R8, R9)
   logic signed [COEF_W-1:0] kp_sel, ki_sel, kd_sel;

   pid_bank_sel #(.NBANK(NBANK), .COEF_W(COEF_W)) u_bank (
      .mode_i   (op_mode_e'(op_mode)),
      .kp_bus_i (kp_banks),
      .ki_bus_i (ki_banks),
      .kd_bus_i (kd_banks),
      .kp_o     (kp_sel),
      .ki_o     (ki_sel),
      .kd_o     (kd_sel)
   );

   // stage 1: error, error difference, operand capture (R1, R7)
   logic signed [E_W-1:0] err_now, err_prev_q;
   logic signed [X_W-1:0] derr_now;
   logic [NSLOT-1:0][X_W-1:0]    x1_q;
   logic [NSLOT-1:0][COEF_W-1:0] c1_q;
   logic v1_q, deriv1_q;

   assign err_now  = $signed({1'b0, ref_code}) - $signed({1'b0, sample_code});
   assign derr_now = X_W'(err_now) - X_W'(err_prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q       <= 1'b0;
         deriv1_q   <= 1'b0;
         err_prev_q <= '0;
         x1_q       <= '0;
         c1_q       <= '0;
      end else begin
         v1_q <= sample_valid;
         if (sample_valid) begin
            err_prev_q   <= err_now;
            deriv1_q     <= use_deriv;
            x1_q[SLOT_P] <= X_W'(err_now);
            x1_q[SLOT_I] <= X_W'(err_now);
            x1_q[SLOT_D] <= derr_now;
            c1_q[SLOT_P] <= kp_sel;
            c1_q[SLOT_I] <= ki_sel;
            c1_q[SLOT_D] <= use_deriv ? kd_sel : '0;
         end
      end
   end

   // stage 2: rounded products (R3)
   logic [NSLOT-1:0][TERM_W-1:0] term_w;
   logic [NSLOT-1:0][TERM_W-1:0] t2_q;
   logic v2_q;

   for (genvar t = 0; t < NSLOT; t++) begin : g_term
      pid_term_mul #(.IN_W(X_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mul (
         .x_i    ($signed(x1_q[t])),
         .coef_i ($signed(c1_q[t])),
         .term_o (term_w[t])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2_q <= 1'b0;
         t2_q <= '0;
      end else begin
         v2_q <= v1_q;
         if (v1_q) t2_q <= term_w;
      end
   end

   // stage 3: integrate, sum, clamp (R4, R5, R6)
   pid_integ_clamp #(.ACC_W(ACC_W), .TERM_W(TERM_W), .DUTY_W(DUTY_W)) u_integ (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (v2_q),
      .p_i      ($signed(t2_q[SLOT_P])),
      .i_i      ($signed(t2_q[SLOT_I])),
      .d_i      ($signed(t2_q[SLOT_D])),
      .dmin_i   (duty_min),
      .dmax_i   (duty_max),
      .duty_o   (duty_cmd),
      .valid_o  (duty_valid)
   );

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> ##3 duty_valid);

   assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> ($stable(c1_q) && $stable(x1_q)));

   assert_pi_no_deriv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (v1_q && !deriv1_q) |=> (t2_q[SLOT_D] == '0));
endmodule

// File: tb/pid_duty_ctrl_tb_top.sv
`timescale 1ns/1ps
module pid_duty_ctrl_tb_top;
   localparam int ERR_W  = 8;
   localparam int DUTY_W = 9;
   localparam int COEF_W = 16;
   localparam int NBANK  = 3;
   localparam int NVEC   = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_valid = 1'b0;
   logic [ERR_W-1:0] sample_code = '0;
   logic [ERR_W-1:0] ref_code = '0;
   logic [1:0] op_mode = '0;
   logic use_deriv = 1'b0;
   logic [NBANK*COEF_W-1:0] kp_banks, ki_banks, kd_banks;
   logic [DUTY_W-1:0] duty_min, duty_max;
   logic [DUTY_W-1:0] duty_cmd;
   logic duty_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pid_duty_ctrl #(.ACC_W(10)) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_code(sample_code), .ref_code(ref_code), .op_mode(op_mode),
      .use_deriv(use_deriv), .kp_banks(kp_banks), .ki_banks(ki_banks),
      .kd_banks(kd_banks), .duty_min(duty_min), .duty_max(duty_max),
      .duty_cmd(duty_cmd), .duty_valid(duty_valid)
   );

   // {sample, ref, mode, use_deriv, expected duty}; gains per bank:
   // bank0 kp 1.0 ki 0.25 kd 0; bank1 kp 2.0 ki 0.5 kd 1.0; bank2 kp 0.5
   localparam logic [27:0] VEC [NVEC] = '{
      {8'd100, 8'd200, 2'd0, 1'b0, 9'd125},
      {8'd150, 8'd200, 2'd0, 1'b0, 9'd88},
      {8'd190, 8'd200, 2'd0, 1'b1, 9'd51},
      {8'd220, 8'd200, 2'd0, 1'b0, 9'd16},
      {8'd230, 8'd200, 2'd0, 1'b0, 9'd16},
      {8'd180, 8'd200, 2'd1, 1'b1, 9'd136},
      {8'd180, 8'd200, 2'd1, 1'b0, 9'd96},
      {8'd10,  8'd200, 2'd1, 1'b1, 9'd480},
      {8'd200, 8'd200, 2'd2, 1'b0, 9'd56},
      {8'd100, 8'd200, 2'd2, 1'b1, 9'd106},
      {8'd140, 8'd200, 2'd3, 1'b0, 9'd86},
      {8'd200, 8'd200, 2'd0, 1'b0, 9'd56}
   };

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // one update; inputs are scrambled after the strobe (R9)
   task automatic do_update(input logic [7:0] smp, input logic [7:0] rf,
                            input logic [1:0] md, input logic dv,
                            output logic [8:0] duty, output logic lat_ok);
      lat_ok = 1'b1;
      @(negedge clk);
      sample_code = smp; ref_code = rf; op_mode = md; use_deriv = dv;
      sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
      sample_code = ~smp; ref_code = rf ^ 8'h5A; op_mode = md + 2'd1;
      use_deriv = ~dv;
      if (duty_valid) lat_ok = 1'b0;
      @(negedge clk);
      if (duty_valid) lat_ok = 1'b0;
      @(negedge clk);
      if (!duty_valid) lat_ok = 1'b0;
      duty = duty_cmd;
      @(negedge clk);
      if (duty_valid) lat_ok = 1'b0;
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R10 reset duty_cmd", int'(duty_cmd), 0);
      check("R10 reset duty_valid", int'(duty_valid), 0);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      logic [8:0] d;
      logic lat;
      kp_banks = {16'sd2048, 16'sd8192, 16'sd4096};
      ki_banks = {16'sd0,    16'sd2048, 16'sd1024};
      kd_banks = {16'sd0,    16'sd4096, 16'sd0};
      duty_min = 9'd16;
      duty_max = 9'd480;

      repeat (3) @(negedge clk);
      check("R10 reset duty_cmd", int'(duty_cmd), 0);
      check("R10 reset duty_valid", int'(duty_valid), 0);
      rst_n = 1'b1;

      // table walk: error sign, rounding, banks, clamp, freeze, hold (R1 R3 R8 R9)
      for (int i = 0; i < NVEC; i++) begin
         logic [27:0] v;
         string tag;
         v = VEC[i];
         do_update(v[27:20], v[19:12], v[11:10], v[9], d, lat);
         tag = $sformatf("R1 R3 R8 R9%s%s%s entry %0d",
                         (i == 3 || i == 4 || i == 7) ? " R6" : "",
                         (i == 5 || i == 8) ? " R5" : "",
                         (i == 2 || i == 5 || i == 6) ? " R7" : "", i);
         check(tag, int'(d), int'(v[8:0]));
         check($sformatf("R2 latency entry %0d", i), int'(lat), 1);
      end

      // reset clears integrator and previous error (R10 R7)
      pulse_reset();
      do_update(8'd190, 8'd200, 2'd1, 1'b1, d, lat);
      check("R10 R7 first PID update after reset", int'(d), 35);

      // integrator saturation: bank2 kp -1.0 ki 1.0, ACC_W=10 limit 511 (R4)
      pulse_reset();
      kp_banks[2*COEF_W +: COEF_W] = 16'hF000;
      ki_banks[2*COEF_W +: COEF_W] = 16'd4096;
      duty_min = 9'd0;
      duty_max = 9'd511;
      do_update(8'd0, 8'd200, 2'd2, 1'b0, d, lat);
      check("R4 sat step 1", int'(d), 0);
      do_update(8'd0, 8'd200, 2'd2, 1'b0, d, lat);
      check("R4 sat step 2", int'(d), 200);
      do_update(8'd0, 8'd200, 2'd2, 1'b0, d, lat);
      check("R4 sat step 3 integrator at limit", int'(d), 311);
      do_update(8'd0, 8'd200, 2'd2, 1'b0, d, lat);
      check("R4 sat step 4 integrator held at limit", int'(d), 311);
      check("R2 latency sat run", int'(lat), 1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #80000;
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end
endmodule